// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned integers of `WIDTH` bits each and gives a product of `2*WIDTH` bits. It works over several clock cycles. A one-cycle `start` pulse captures the multiplicand into a holding register M and the multiplier into the low product register Q. The same pulse clears the high product register A. After that the block does one step per clock. In each step it looks at the current bit Q[0]. If that bit is 1, it adds M to A. It then shifts the pair A:Q right by one bit. The carry out of the addition enters A at the top, and A's lowest bit enters Q at the top.

The sequencing is a small state machine with three states:
- `ST_IDLE`: waiting for `start`.
- `ST_RUN`: one step per cycle, with a down-counter for the steps left.
- `ST_FIN`: lasts one cycle and raises `done`.

The transitions are as follows:
- IDLE→RUN when `start` is high.
- RUN→RUN while more than one step remains.
- RUN→FIN on the last step.
- FIN→IDLE when there is no `start`.
- FIN→RUN when there is a `start`.

A start that arrives during RUN is ignored. The product output shows the concatenation A:Q at all times. After `done` it keeps its value until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled while `busy` is 0 loads the operands. In the next cycle `busy` is 1 and `product` equals {WIDTH zero bits, mplier}.
- R3: After s completed steps (1 ≤ s ≤ WIDTH), `product` equals (mcand × (mplier mod 2^s)) × 2^(WIDTH−s) plus (mplier >> s). Each step adds M only when the current Q[0] is 1, then shifts A:Q right by one bit with the adder carry entering the MSB of A.
- R4: `busy` stays high for exactly WIDTH cycles after an accepted start.
- R5: When `done` is high, `product` equals mcand × mplier. The upper WIDTH bits (A) hold the high half and the lower WIDTH bits (Q) hold the low half. For example, 11 × 13 gives 143.
- R6: A `start` sampled while `busy` is 1 has no effect. Neither the step sequence nor the operands in use change.
- R7: Once `done` has been seen, `product` holds its value, whatever the operand inputs do, until the next accepted start.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last step, when `busy` has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that requests a new multiplication |
| mcand | input | WIDTH | Multiplicand, sampled with an accepted start |
| mplier | input | WIDTH | Multiplier, sampled with an accepted start |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse: the product is complete |
| product | output | 2*WIDTH | Current A:Q; the final product once done |

## Verification
Take the clock edge that accepts a start as edge 0. The loaded value is visible after edge 0. The partial result after step s is visible after edge s. `done` and the final product appear after edge WIDTH, and `done` drops after edge WIDTH+1.

The bench keeps a behavioural reference with a step counter that advances on the same rising edges. It compares `busy`, `done` and `product` against that reference at every falling edge. Each comparison therefore falls exactly in the cycle the design should produce its value. Starts sent during a run, and operand changes after completion, go through the same per-cycle comparison.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(WIDTH);

    mul_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             last_step;

    assign last_step = (left_q == CNT_W'(1));

    // next-state and counter
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    left_d  = STEPS;
                end
            end
            ST_RUN: begin
                left_d = left_q - CNT_W'(1);
                if (last_step) state_d = ST_FIN;
            end
            ST_FIN: begin
                if (start) begin
                    state_d = ST_RUN;
                    left_d  = STEPS;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FIN: begin
                load = start;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r4_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last_step) |=> (state_q == ST_RUN));
    a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product
);
    logic [WIDTH-1:0] m_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] q_q;
    logic [WIDTH:0]   sum;   // carry bit plus A

    // conditional add: M only when the current multiplier bit is set
    assign sum = {1'b0, a_q} + (q_q[0] ? {1'b0, m_q} : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
            a_q <= '0;
            q_q <= '0;
        end else if (load) begin
            m_q <= mcand;
            a_q <= '0;
            q_q <= mplier;
        end else if (step) begin
            a_q <= sum[WIDTH:1];
            q_q <= {sum[0], q_q[WIDTH-1:1]};
        end
    end

    assign product = {a_q, q_q};

    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (a_q == '0 && q_q == $past(mplier)));
    a_r3_q_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (q_q[WIDTH-2:0] == $past(q_q[WIDTH-1:1])));
    a_r3_skip_add: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !q_q[0]) |=> ({a_q, q_q} == ($past({a_q, q_q}) >> 1)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(a_q) && $stable(q_q) && $stable(m_q)));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load;
    logic step;

    initial begin
        a_r3_width_ok: assert (WIDTH >= 2);
    end

    mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );

    a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> (!busy && !done));
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] mcand = '0;
    logic [W-1:0] mplier = '0;
    logic busy, done;
    logic [2*W-1:0] product;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // reference model state
    int m_phase = 0;       // 0 idle, 1 running, 2 finished
    int m_steps = 0;
    longint unsigned m_mc = 0, m_mp = 0, m_prod = 0;
    string m_tag = "R1";

    shift_add_mul #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
        .mplier(mplier), .busy(busy), .done(done), .product(product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_steps = 0; m_prod = 0; m_tag = "R1";
        end else if (m_phase != 1 && start) begin
            m_mc = longint'(mcand); m_mp = longint'(mplier);
            m_steps = 0; m_phase = 1; m_prod = m_mp; m_tag = "R2";
        end else if (m_phase == 1) begin
            m_steps++;
            m_prod = ((m_mc * (m_mp & ((64'd1 << m_steps) - 1))) << (W - m_steps))
                     | (m_mp >> m_steps);
            m_tag = "R3";
            if (m_steps == W) begin
                m_phase = 2; m_tag = "R5";
            end
        end else if (m_phase == 2) begin
            m_phase = 0; m_tag = "R7";
        end
    end

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        check("R4", longint'(busy), (m_phase == 1) ? 1 : 0);
        check("R8", longint'(done), (m_phase == 2) ? 1 : 0);
        check(m_tag, longint'(product), m_prod);
    endtask

    // one cycle: compare at falling edge, then drive
    task automatic cyc(input logic st, input logic [W-1:0] mc, input logic [W-1:0] mp);
        @(negedge clk);
        compare_all();
        start = st; mcand = mc; mplier = mp;
    endtask

    task automatic run_op(input logic [W-1:0] mc, input logic [W-1:0] mp);
        cyc(1'b1, mc, mp);
        for (int i = 0; i < W + 1; i++) cyc(1'b0, mc, mp);
        // done cycle is now observed; check R5 against the plain product
        check("R5", longint'(product), longint'(mc) * longint'(mp));
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", longint'(busy), 0);
        check("R1", longint'(done), 0);
        check("R1", longint'(product), 0);
        rst_n = 1'b1;
        cyc(1'b0, '0, '0);

        // R5: 11 x 13 = 143
        cyc(1'b1, 8'd11, 8'd13);
        for (int i = 0; i < W; i++) cyc(1'b0, 8'd0, 8'd0);
        @(negedge clk);
        check("R5", longint'(done), 1);
        check("R5", longint'(product), 143);
        cyc(1'b0, '0, '0);

        // corner operands
        run_op(8'd0, 8'd200);
        run_op(8'd200, 8'd0);
        run_op(8'd1, 8'd173);
        run_op(8'd173, 8'd1);
        run_op(8'hFF, 8'hFF);
        run_op(8'h80, 8'h01);

        // R6: starts while busy with new operands are ignored
        cyc(1'b1, 8'd37, 8'd91);
        for (int i = 0; i < W - 1; i++) cyc(1'b1, 8'(i * 17 + 5), 8'(255 - i));
        cyc(1'b0, '0, '0);
        @(negedge clk);
        check("R6", longint'(product), 37 * 91);
        cyc(1'b0, '0, '0);

        // R7: product holds while operands wiggle without start
        for (int i = 0; i < 6; i++) cyc(1'b0, 8'(i * 41), 8'(i * 29 + 3));
        @(negedge clk);
        check("R7", longint'(product), 37 * 91);

        // back-to-back: start in the done cycle
        cyc(1'b1, 8'd250, 8'd251);
        for (int i = 0; i < W; i++) cyc(1'b0, '0, '0);
        cyc(1'b1, 8'd19, 8'd23);
        for (int i = 0; i < W + 2; i++) cyc(1'b0, '0, '0);

        // random operands
        for (int n = 0; n < 40; n++) run_op(8'($urandom), 8'($urandom));

        @(negedge clk);
        compare_all();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule